// File: doc/BRIEF.md
# Dual-Issue Pairing Controller

This block sits at the decode stage of an in-order, two-wide pipeline. Each cycle the front end presents up to two decoded candidates, the older one in slot 0 and the younger one in slot 1. Each candidate carries a valid bit and a three-bit issue-group code. The block raises `issue0` and `issue1` in the same cycle to say which candidates leave decode. The front end shifts out whatever issued. A younger candidate that was held back becomes the slot 0 candidate on the next cycle.

Pairing follows a fixed conflict matrix over the groups. Each illegal pair comes from two instructions that would need the same single shared resource: the integer unit, the branch address adder, the load-store port or the first floating-point stage. Complex ("solo") instructions take both decode slots. Some solo kinds keep decode locked for several cycles. A small down-counter holds both strobes low and raises `stall` for the rest of that window.

Top module: `issue_pair_ctrl`

## Requirements
- R1: Group codes are 0 = MT, 1 = EX, 2 = BR, 3 = LS, 4 = FE, 5 = SOLO. Codes 6 and 7 behave as SOLO. When decode is not locked, a valid slot 0 candidate always issues (`issue0` = 1) in the same cycle.
- R2: Issue is in order. `issue1` is never high unless `issue0` is high. If slot 0 is invalid, nothing issues.
- R3: A SOLO candidate in either slot prevents pairing. A SOLO in slot 0 issues alone, and a SOLO in slot 1 is held back.
- R4: The pairs EX+EX, EX+BR and BR+BR, in either slot order, do not pair. Only slot 0 issues.
- R5: The pairs BR+LS and LS+LS, in either slot order, do not pair.
- R6: The pair FE+FE does not pair.
- R7: Every other pair of two valid non-SOLO candidates issues both: MT with any non-SOLO group, EX+LS, EX+FE, BR+FE and LS+FE.
- R8: A SOLO issued from slot 0 locks decode for a total of N cycles, counting its issue cycle. N is selected by the 3-bit lock kind: 0 = 1, 1 (return / indirect jump) = 2, 2 (exception return) = 5, 3 (call) = 16, 4 (procedure-register move) = 2, and 5 to 7 = 1.
- R9: During the N-1 cycles after a locking SOLO issues, `stall` is 1 and both strobes are 0, whatever the inputs. In the cycle after that, `stall` is 0 and issue resumes.
- R10: A synchronous active-high reset clears any lock. `stall` is 0 in the first cycle after reset, and a SOLO presented during reset starts no lock.
- R11: An invalid slot is ignored. An invalid SOLO in slot 0 starts no lock, so `stall` stays 0 in the next cycle. An invalid slot 1 never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0_valid | input | 1 | Older candidate present |
| slot0_group | input | 3 | Older candidate issue group |
| slot0_lock | input | 3 | Lock kind of the older candidate (used when it is SOLO) |
| slot1_valid | input | 1 | Younger candidate present |
| slot1_group | input | 3 | Younger candidate issue group |
| issue0 | output | 1 | Older candidate leaves decode this cycle |
| issue1 | output | 1 | Younger candidate leaves decode this cycle |
| stall | output | 1 | Decode is locked by an earlier SOLO instruction |

## Verification
The bench builds the block with its default lock lengths of 2, 5, 16 and 2 cycles. The 16-cycle call window therefore drives the counter to its largest load value of 15 and counts it down to zero. The bench sweeps all 64 group pairs under all four valid combinations, with the lock kind rotating across the sweep. Every locking SOLO that issues is followed through its whole window and through the first free cycle after it. This covers the undefined codes 6 and 7 and every lock kind, including the unused kind codes.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

    localparam int unsigned GRP_W   = 3;
    localparam int unsigned N_GRP   = 1 << GRP_W;
    localparam int unsigned KIND_W  = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_MT   = 3'd0,
        GRP_EX   = 3'd1,
        GRP_BR   = 3'd2,
        GRP_LS   = 3'd3,
        GRP_FE   = 3'd4,
        GRP_SOLO = 3'd5,
        GRP_RSV6 = 3'd6,
        GRP_RSV7 = 3'd7
    } grp_e;

    typedef enum logic [KIND_W-1:0] {
        LK_SINGLE = 3'd0,
        LK_RETURN = 3'd1,
        LK_EXCRET = 3'd2,
        LK_CALL   = 3'd3,
        LK_PRMOVE = 3'd4
    } lock_kind_e;

    typedef struct packed {
        logic             valid;
        logic [GRP_W-1:0] grp;
    } slot_t;

    // Any code at or above SOLO takes both decode slots.
    function automatic logic is_solo(input logic [GRP_W-1:0] g);
        return g >= GRP_SOLO;
    endfunction

    // Do two groups contend for one shared resource in the same cycle?
    function automatic logic groups_conflict(input logic [GRP_W-1:0] a,
                                             input logic [GRP_W-1:0] b);
        logic int_a, int_b, adr_a, adr_b, lsp_a, lsp_b, fp_a, fp_b;
        if (is_solo(a) || is_solo(b))
            return 1'b1;
        // integer unit: EX, and BR in its execute stage
        int_a = (a == GRP_EX) || (a == GRP_BR);
        int_b = (b == GRP_EX) || (b == GRP_BR);
        // branch adder / load-store port at issue
        adr_a = (a == GRP_BR) || (a == GRP_LS);
        adr_b = (b == GRP_BR) || (b == GRP_LS);
        lsp_a = (a == GRP_LS);
        lsp_b = (b == GRP_LS);
        fp_a  = (a == GRP_FE);
        fp_b  = (b == GRP_FE);
        // EX with EX/BR, BR with BR/LS, LS with LS, FE with FE
        if (int_a && int_b)
            return 1'b1;
        if ((a == GRP_BR && adr_b) || (b == GRP_BR && adr_a))
            return 1'b1;
        if (lsp_a && lsp_b)
            return 1'b1;
        return fp_a && fp_b;
    endfunction

endpackage

// File: rtl/pair_rules.sv
module pair_rules
    import issue_pair_pkg::*;
(
    input  logic [GRP_W-1:0] grp_old,
    input  logic [GRP_W-1:0] grp_young,
    output logic             pair_ok
);

    logic [N_GRP*N_GRP-1:0] ok_tbl;

    for (genvar a = 0; a < N_GRP; a++) begin : g_row
        for (genvar b = 0; b < N_GRP; b++) begin : g_col
            assign ok_tbl[a*N_GRP + b] =
                !groups_conflict(GRP_W'(a), GRP_W'(b));
        end
    end

    assign pair_ok = ok_tbl[{grp_old, grp_young}];

endmodule

// File: rtl/lock_timer.sv
module lock_timer
    import issue_pair_pkg::*;
#(
    parameter int unsigned LEN_RETURN = 2,
    parameter int unsigned LEN_EXCRET = 5,
    parameter int unsigned LEN_CALL   = 16,
    parameter int unsigned LEN_PRMOVE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [KIND_W-1:0] kind,
    output logic              busy
);

    localparam int unsigned MAX_A   = (LEN_RETURN > LEN_EXCRET) ? LEN_RETURN : LEN_EXCRET;
    localparam int unsigned MAX_B   = (LEN_CALL > LEN_PRMOVE) ? LEN_CALL : LEN_PRMOVE;
    localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    localparam logic [CW-1:0] X_RETURN = CW'(LEN_RETURN - 1);
    localparam logic [CW-1:0] X_EXCRET = CW'(LEN_EXCRET - 1);
    localparam logic [CW-1:0] X_CALL   = CW'(LEN_CALL - 1);
    localparam logic [CW-1:0] X_PRMOVE = CW'(LEN_PRMOVE - 1);

    logic [CW-1:0] remain_q;
    logic [CW-1:0] extra;

    // Cycles still blocked after the issue cycle.
    always_comb begin
        unique case (kind)
            LK_RETURN: extra = X_RETURN;
            LK_EXCRET: extra = X_EXCRET;
            LK_CALL:   extra = X_CALL;
            LK_PRMOVE: extra = X_PRMOVE;
            default:   extra = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
        else if (load)
            remain_q <= extra;
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/issue_pair_ctrl.sv
module issue_pair_ctrl
    import issue_pair_pkg::*;
#(
    parameter int unsigned LEN_RETURN = 2,
    parameter int unsigned LEN_EXCRET = 5,
    parameter int unsigned LEN_CALL   = 16,
    parameter int unsigned LEN_PRMOVE = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot0_valid,
    input  logic [2:0] slot0_group,
    input  logic [2:0] slot0_lock,
    input  logic       slot1_valid,
    input  logic [2:0] slot1_group,
    output logic       issue0,
    output logic       issue1,
    output logic       stall
);

    slot_t old_s, young_s;
    logic  pair_ok;
    logic  locked;
    logic  start_lock;

    assign old_s   = '{valid: slot0_valid, grp: slot0_group};
    assign young_s = '{valid: slot1_valid, grp: slot1_group};

    pair_rules u_rules (
        .grp_old   (old_s.grp),
        .grp_young (young_s.grp),
        .pair_ok   (pair_ok)
    );

    lock_timer #(
        .LEN_RETURN (LEN_RETURN),
        .LEN_EXCRET (LEN_EXCRET),
        .LEN_CALL   (LEN_CALL),
        .LEN_PRMOVE (LEN_PRMOVE)
    ) u_lock (
        .clk  (clk),
        .rst  (rst),
        .load (start_lock),
        .kind (slot0_lock),
        .busy (locked)
    );

    assign issue0     = old_s.valid && !locked;
    assign issue1     = issue0 && young_s.valid && pair_ok;
    assign start_lock = issue0 && is_solo(old_s.grp);
    assign stall      = locked;

endmodule

// File: rtl/issue_pair_chk.sv
module issue_pair_chk
    import issue_pair_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       slot0_valid,
    input logic [2:0] slot0_group,
    input logic [2:0] slot0_lock,
    input logic       slot1_valid,
    input logic [2:0] slot1_group,
    input logic       issue0,
    input logic       issue1,
    input logic       stall
);

    p_free_issue_r1: assert property (@(posedge clk) disable iff (rst)
        (slot0_valid && !stall) |-> issue0);

    p_in_order_r2: assert property (@(posedge clk) disable iff (rst)
        issue1 |-> (issue0 && slot1_valid));

    p_solo_alone_r3: assert property (@(posedge clk) disable iff (rst)
        issue1 |-> (!is_solo(slot0_group) && !is_solo(slot1_group)));

    p_int_branch_r4: assert property (@(posedge clk) disable iff (rst)
        issue1 |-> !((slot0_group inside {GRP_EX, GRP_BR}) &&
                     (slot1_group inside {GRP_EX, GRP_BR})));

    p_ls_port_r5: assert property (@(posedge clk) disable iff (rst)
        issue1 |-> !((slot0_group inside {GRP_BR, GRP_LS}) &&
                     (slot1_group inside {GRP_BR, GRP_LS}) &&
                     !(slot0_group == GRP_BR && slot1_group == GRP_BR) &&
                     (slot0_group == GRP_LS || slot1_group == GRP_LS)));

    p_fp_stage_r6: assert property (@(posedge clk) disable iff (rst)
        issue1 |-> !(slot0_group == GRP_FE && slot1_group == GRP_FE));

    p_lock_start_r8: assert property (@(posedge clk) disable iff (rst)
        (issue0 && is_solo(slot0_group) &&
         (slot0_lock inside {LK_RETURN, LK_EXCRET, LK_CALL, LK_PRMOVE}))
        |=> stall);

    p_single_free_r8: assert property (@(posedge clk) disable iff (rst)
        (issue0 && is_solo(slot0_group) &&
         !(slot0_lock inside {LK_RETURN, LK_EXCRET, LK_CALL, LK_PRMOVE}))
        |=> !stall);

    p_locked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!issue0 && !issue1));

    p_invalid_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (!slot0_valid && !stall) |=> !stall);

endmodule

bind issue_pair_ctrl issue_pair_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot0_valid (slot0_valid),
    .slot0_group (slot0_group),
    .slot0_lock  (slot0_lock),
    .slot1_valid (slot1_valid),
    .slot1_group (slot1_group),
    .issue0      (issue0),
    .issue1      (issue1),
    .stall       (stall)
);

// File: tb/issue_pair_ctrl_bench.sv
`timescale 1ns/1ps
module issue_pair_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot0_valid = 1'b0;
    logic [2:0] slot0_group = 3'd0;
    logic [2:0] slot0_lock  = 3'd0;
    logic       slot1_valid = 1'b0;
    logic [2:0] slot1_group = 3'd0;
    logic       issue0, issue1, stall;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    issue_pair_ctrl u_issue_pair_ctrl (
        .clk(clk), .rst(rst),
        .slot0_valid(slot0_valid), .slot0_group(slot0_group), .slot0_lock(slot0_lock),
        .slot1_valid(slot1_valid), .slot1_group(slot1_group),
        .issue0(issue0), .issue1(issue1), .stall(stall)
    );

    task automatic check(input string req, input string what,
                         input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, actual, expected);
        end
    endtask

    // Expected pairing from the requirements.
    function automatic bit can_pair(input int a, input int b);
        int lo, hi;
        if (a >= 5 || b >= 5) return 1'b0;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (lo == 1 && (hi == 1 || hi == 2)) return 1'b0;
        if (lo == 2 && (hi == 2 || hi == 3)) return 1'b0;
        if (lo == 3 && hi == 3) return 1'b0;
        if (lo == 4 && hi == 4) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string pair_req(input int a, input int b);
        int lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (a >= 5 || b >= 5) return "R3";
        if (lo == 1 && hi <= 2) return "R4";
        if (lo == 2 && hi == 2) return "R4";
        if ((lo == 2 && hi == 3) || (lo == 3 && hi == 3)) return "R5";
        if (lo == 4 && hi == 4) return "R6";
        return "R7";
    endfunction

    function automatic int lock_len(input int kind);
        case (kind)
            1: return 2;
            2: return 5;
            3: return 16;
            4: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic drive(input bit v0, input int g0, input int k0,
                         input bit v1, input int g1);
        @(negedge clk);
        slot0_valid = v0; slot0_group = 3'(g0); slot0_lock = 3'(k0);
        slot1_valid = v1; slot1_group = 3'(g1);
        #1;
    endtask

    // Follow a lock window: N-1 blocked cycles, then a free one.
    task automatic follow_lock(input int kind);
        int n;
        n = lock_len(kind);
        for (int i = 1; i < n; i++) begin
            drive(1'b1, 0, 0, 1'b1, 0);
            check("R9", "stall in window", stall, 1'b1);
            check("R9", "issue0 in window", issue0, 1'b0);
            check("R9", "issue1 in window", issue1, 1'b0);
        end
        drive(1'b1, 0, 0, 1'b1, 0);
        check("R8", "stall after window", stall, 1'b0);
        check("R8", "issue0 after window", issue0, 1'b1);
        check("R7", "issue1 after window", issue1, 1'b1);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R10: a SOLO presented during reset must start no lock.
        slot0_valid = 1'b1; slot0_group = 3'd5; slot0_lock = 3'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        slot0_valid = 1'b1; slot0_group = 3'd0; slot1_valid = 1'b0;
        #1;
        check("R10", "stall after reset", stall, 1'b0);
        check("R10", "issue0 after reset", issue0, 1'b1);

        // R10: reset in the middle of a call window.
        drive(1'b1, 5, 3, 1'b0, 0);
        check("R8", "call issues", issue0, 1'b1);
        repeat (3) drive(1'b1, 0, 0, 1'b0, 0);
        check("R9", "mid-call stall", stall, 1'b1);
        rst = 1'b1;
        drive(1'b1, 0, 0, 1'b1, 0);
        rst = 1'b0;
        drive(1'b1, 0, 0, 1'b1, 0);
        check("R10", "stall cleared by reset", stall, 1'b0);
        check("R10", "issue resumes after reset", issue0, 1'b1);

        // R11: an invalid SOLO starts no lock.
        drive(1'b0, 5, 3, 1'b1, 0);
        check("R2", "invalid slot0 issue0", issue0, 1'b0);
        check("R2", "invalid slot0 issue1", issue1, 1'b0);
        drive(1'b1, 0, 0, 1'b0, 0);
        check("R11", "no lock from invalid solo", stall, 1'b0);

        // Every lock kind in turn.
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 5 + (k % 3), k, 1'b1, 0);
            check("R3", "solo issues alone", issue1, 1'b0);
            follow_lock(k);
        end

        // Sweep all group pairs under all valid combinations.
        for (int vv = 0; vv < 4; vv++) begin
            for (int g0 = 0; g0 < 8; g0++) begin
                for (int g1 = 0; g1 < 8; g1++) begin
                    bit v0, v1, e1;
                    int k;
                    v0 = vv[1];
                    v1 = vv[0];
                    k  = (g0 * 8 + g1 + vv) % 8;
                    drive(v0, g0, k, v1, g1);
                    check("R11", "no stale lock", stall, 1'b0);
                    check("R1", "issue0", issue0, v0);
                    e1 = v0 && v1 && can_pair(g0, g1);
                    if (!v0)
                        check("R2", "issue1 without slot0", issue1, e1);
                    else if (!v1)
                        check("R11", "issue1 invalid slot1", issue1, e1);
                    else
                        check(pair_req(g0, g1), "issue1 pairing", issue1, e1);
                    if (v0 && g0 >= 5)
                        follow_lock(k);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule